// File: doc/BRIEF.md
# Configurable Logic Element Cell

One programmable cell of a small-array logic fabric. A four-input lookup table is filled from a 16-bit configuration word. An arithmetic path can take its place: it computes one bit of addition or subtraction, and the direction is chosen at run time by a block-wide control. Carry is computed on two rails at once. Each rail assumes its own incoming carry, and a block-level select picks the rail that feeds the sum bit.

The cell's flip-flop can be configured to act as a D, T, JK or SR element. Its clock, clock enable and asynchronous clear are each picked from a pair of block-wide lines by a static configuration bit. On top of that come a synchronous clear and a synchronous load, an asynchronous preset-or-load path, a chip-wide active-low reset, a bypass that sends the combinational result straight to the cell output, a packed mode that registers a data input directly, and a register chain that links neighbouring cells. The combinational result also leaves the cell so that the next cell can use it.

Top module: `lec_cell`

## Requirements
- R1: With `cfg_arith_i`=0, `comb_o` equals `cfg_lut_i[data_i]`. `data_i[0]` is the least significant index bit.
- R2: With `cfg_arith_i`=1, `comb_o` = `data_i[0]` ^ `b` ^ `c`. Here `b` = `data_i[1]` when `addnsub_i`=1 (add) and `~data_i[1]` when `addnsub_i`=0 (subtract). `c` is `cin1_i` when `cin_sel_i`=1 and `cin0_i` otherwise.
- R3: `cout0_o` is the majority of (`data_i[0]`, `b`, `cin0_i`). `cout1_o` is the majority of (`data_i[0]`, `b`, `cin1_i`).
- R4: In D mode (`cfg_ff_i`=00), an enabled clock edge loads the register input. That input is chosen in this priority order: `chain_i` when `cfg_chain_i`=1, then `data_i[3]` when `cfg_pack_i`=1, then `comb_o`.
- R5: In T mode (01) the register toggles when its input is 1. In JK mode (10), J is the register input and K is `data_i[2]`: 00 holds, J alone sets, K alone clears, both toggle. In SR mode (11), S is the register input and R is `data_i[2]`: S alone sets, R alone clears, 00 and 11 hold.
- R6: The clock enable is `ena1_i` when `cfg_ena_sel_i`=1 and `ena0_i` otherwise. With the enable low, the register holds.
- R7: The register clocks on `clk1_i` when `cfg_clk_sel_i`=1 and on `clk0_i` otherwise. Edges of the other clock have no effect.
- R8: At an enabled edge, `sclr_i` clears the register. Otherwise `sload_i` loads `data_i[2]`. Both override the flip-flop function. With the enable low, neither acts.
- R9: The register clears at once, without a clock, when `rst_ni` is low or when the selected clear line is high (`aclr1_i` if `cfg_clr_sel_i`=1, else `aclr0_i`). The unselected clear line has no effect. Clear wins over preset.
- R10: When `apre_i` rises, the register takes `adata_i` if `cfg_aload_i`=1 and 1 otherwise. It keeps that value, ignoring clock edges, while `apre_i` stays high.
- R11: `cell_o` is `comb_o` when `cfg_bypass_i`=1 and the register value otherwise. `chain_o` is always the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Block clock 0 |
| clk1_i | input | 1 | Block clock 1 |
| rst_ni | input | 1 | Chip-wide asynchronous reset, active low |
| ena0_i | input | 1 | Block clock enable 0 |
| ena1_i | input | 1 | Block clock enable 1 |
| aclr0_i | input | 1 | Block asynchronous clear 0, active high |
| aclr1_i | input | 1 | Block asynchronous clear 1, active high |
| apre_i | input | 1 | Asynchronous preset/load strobe |
| adata_i | input | 1 | Asynchronous load data |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous load of data_i[2] |
| addnsub_i | input | 1 | 1 = add, 0 = subtract |
| data_i | input | 4 | Cell data inputs; bit 0 is the first operand |
| cin0_i | input | 1 | Carry in, rail 0 |
| cin1_i | input | 1 | Carry in, rail 1 |
| cin_sel_i | input | 1 | Block carry-in: selects the rail that feeds the sum |
| chain_i | input | 1 | Register chain from the previous cell |
| cfg_lut_i | input | 16 | Truth table |
| cfg_arith_i | input | 1 | Arithmetic mode |
| cfg_ff_i | input | 2 | Flip-flop kind: 00 D, 01 T, 10 JK, 11 SR |
| cfg_clk_sel_i | input | 1 | Clock select |
| cfg_ena_sel_i | input | 1 | Enable select |
| cfg_clr_sel_i | input | 1 | Asynchronous clear select |
| cfg_aload_i | input | 1 | 1 = asynchronous load of adata_i, 0 = preset |
| cfg_bypass_i | input | 1 | Route comb_o to cell_o |
| cfg_pack_i | input | 1 | Register data_i[3] directly |
| cfg_chain_i | input | 1 | Register chain_i |
| comb_o | output | 1 | Combinational result, also the chain output to the next cell's table |
| cell_o | output | 1 | Cell output |
| chain_o | output | 1 | Register chain output |
| cout0_o | output | 1 | Carry out, rail 0 |
| cout1_o | output | 1 | Carry out, rail 1 |

## Verification
The table is swept through all sixteen index values under three truth tables: an AND, a four-way parity and an irregular pattern. These separate the correct bit order from a reversed or shifted index. The arithmetic path is swept over every combination of operands, both rail carries, the rail select and both directions. Unequal carries on the two rails expose a swapped rail, and the subtract cases expose a missing inversion. The register modes are driven through sequences that reach each of set, clear, hold and toggle. Conflicting controls are applied in the same cycle (clear with load, chain with packed data, clear with preset) so that each priority order is pinned down.

// File: rtl/lec_pkg.sv
package lec_pkg;
  typedef enum logic [1:0] {FF_D = 2'b00, FF_T = 2'b01, FF_JK = 2'b10, FF_SR = 2'b11} ff_kind_e;
  localparam int LUT_IN_DEF = 4;
endpackage

// File: rtl/lec_lut.sv
module lec_lut #(
  parameter int N_IN = 4,
  localparam int W = 1 << N_IN
) (
  input  logic [W-1:0]    cfg_i,
  input  logic [N_IN-1:0] sel_i,
  output logic            y_o
);
  assign y_o = cfg_i[sel_i];
endmodule

// File: rtl/lec_carry.sv
module lec_carry #(
  parameter int RAILS = 2
) (
  input  logic             a_i,
  input  logic             b_i,
  input  logic             add_i,
  input  logic [RAILS-1:0] cin_i,
  input  logic             rail_sel_i,
  output logic             sum_o,
  output logic [RAILS-1:0] cout_o
);
  logic b_x;
  assign b_x = b_i ^ ~add_i;

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    assign cout_o[r] = (a_i & b_x) | (cin_i[r] & (a_i ^ b_x));
  end

  assign sum_o = a_i ^ b_x ^ cin_i[rail_sel_i];
endmodule

// File: rtl/lec_reg.sv
module lec_reg
  import lec_pkg::*;
(
  input  logic     clk0_i,
  input  logic     clk1_i,
  input  logic     clk_sel_i,
  input  logic     ena0_i,
  input  logic     ena1_i,
  input  logic     ena_sel_i,
  input  logic     rst_ni,
  input  logic     aclr0_i,
  input  logic     aclr1_i,
  input  logic     clr_sel_i,
  input  logic     apre_i,
  input  logic     aload_i,
  input  logic     adata_i,
  input  logic     sclr_i,
  input  logic     sload_i,
  input  logic     sload_d_i,
  input  ff_kind_e kind_i,
  input  logic     din_i,
  input  logic     kin_i,
  output logic     q_o
);
  logic clk_g, en, aclr, q, nxt;

  assign clk_g = clk_sel_i ? clk1_i : clk0_i;
  assign en    = ena_sel_i ? ena1_i : ena0_i;
  assign aclr  = ~rst_ni | (clr_sel_i ? aclr1_i : aclr0_i);

  always_comb begin
    nxt = q;
    unique case (kind_i)
      FF_D:  nxt = din_i;
      FF_T:  nxt = q ^ din_i;
      FF_JK: case ({din_i, kin_i})
               2'b10:   nxt = 1'b1;
               2'b01:   nxt = 1'b0;
               2'b11:   nxt = ~q;
               default: nxt = q;
             endcase
      FF_SR: case ({din_i, kin_i})
               2'b10:   nxt = 1'b1;
               2'b01:   nxt = 1'b0;
               default: nxt = q;
             endcase
      default: nxt = q;
    endcase
  end

  // clear beats preset; sync clear beats sync load beats flip-flop function
  always_ff @(posedge clk_g or posedge aclr or posedge apre_i) begin
    if (aclr)        q <= 1'b0;
    else if (apre_i) q <= aload_i ? adata_i : 1'b1;
    else if (en) begin
      if (sclr_i)       q <= 1'b0;
      else if (sload_i) q <= sload_d_i;
      else              q <= nxt;
    end
  end

  assign q_o = q;

  assert_sclr_R8: assert property (@(posedge clk_g) disable iff (aclr || apre_i)
    en && sclr_i |=> q == 1'b0);
  assert_hold_R6: assert property (@(posedge clk_g) disable iff (aclr || apre_i)
    !en |=> $stable(q));
  assert_dff_R4: assert property (@(posedge clk_g) disable iff (aclr || apre_i)
    en && !sclr_i && !sload_i && kind_i == FF_D |=> q == $past(din_i));
  assert_jk_toggle_R5: assert property (@(posedge clk_g) disable iff (aclr || apre_i)
    en && !sclr_i && !sload_i && kind_i == FF_JK && din_i && kin_i |=> q != $past(q));
endmodule

// File: rtl/lec_cell.sv
module lec_cell
  import lec_pkg::*;
#(
  parameter int LUT_IN = LUT_IN_DEF,
  localparam int LUT_W = 1 << LUT_IN
) (
  input  logic              clk0_i,
  input  logic              clk1_i,
  input  logic              rst_ni,
  input  logic              ena0_i,
  input  logic              ena1_i,
  input  logic              aclr0_i,
  input  logic              aclr1_i,
  input  logic              apre_i,
  input  logic              adata_i,
  input  logic              sclr_i,
  input  logic              sload_i,
  input  logic              addnsub_i,
  input  logic [LUT_IN-1:0] data_i,
  input  logic              cin0_i,
  input  logic              cin1_i,
  input  logic              cin_sel_i,
  input  logic              chain_i,
  input  logic [LUT_W-1:0]  cfg_lut_i,
  input  logic              cfg_arith_i,
  input  logic [1:0]        cfg_ff_i,
  input  logic              cfg_clk_sel_i,
  input  logic              cfg_ena_sel_i,
  input  logic              cfg_clr_sel_i,
  input  logic              cfg_aload_i,
  input  logic              cfg_bypass_i,
  input  logic              cfg_pack_i,
  input  logic              cfg_chain_i,
  output logic              comb_o,
  output logic              cell_o,
  output logic              chain_o,
  output logic              cout0_o,
  output logic              cout1_o
);
  logic       lut_y, sum, comb, din, q;
  logic [1:0] cout;

  lec_lut #(.N_IN(LUT_IN)) u_lut (
    .cfg_i(cfg_lut_i), .sel_i(data_i), .y_o(lut_y)
  );

  lec_carry #(.RAILS(2)) u_carry (
    .a_i(data_i[0]), .b_i(data_i[1]), .add_i(addnsub_i),
    .cin_i({cin1_i, cin0_i}), .rail_sel_i(cin_sel_i),
    .sum_o(sum), .cout_o(cout)
  );

  assign comb = cfg_arith_i ? sum : lut_y;
  assign din  = cfg_chain_i ? chain_i : (cfg_pack_i ? data_i[3] : comb);

  lec_reg u_reg (
    .clk0_i(clk0_i), .clk1_i(clk1_i), .clk_sel_i(cfg_clk_sel_i),
    .ena0_i(ena0_i), .ena1_i(ena1_i), .ena_sel_i(cfg_ena_sel_i),
    .rst_ni(rst_ni), .aclr0_i(aclr0_i), .aclr1_i(aclr1_i), .clr_sel_i(cfg_clr_sel_i),
    .apre_i(apre_i), .aload_i(cfg_aload_i), .adata_i(adata_i),
    .sclr_i(sclr_i), .sload_i(sload_i), .sload_d_i(data_i[2]),
    .kind_i(ff_kind_e'(cfg_ff_i)), .din_i(din), .kin_i(data_i[2]),
    .q_o(q)
  );

  assign comb_o  = comb;
  assign cell_o  = cfg_bypass_i ? comb : q;
  assign chain_o = q;
  assign cout0_o = cout[0];
  assign cout1_o = cout[1];

  // rails see the same carry in -> they must agree
  assert_rail_R3: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    (cin0_i == cin1_i) |-> (cout0_o == cout1_o));
endmodule

// File: tb/sim_lec_cell.sv
module sim_lec_cell;
  logic clk0_i = 0, clk1_i = 0, rst_ni = 0;
  logic ena0_i = 1, ena1_i = 0, aclr0_i = 0, aclr1_i = 0, apre_i = 0, adata_i = 0;
  logic sclr_i = 0, sload_i = 0, addnsub_i = 1;
  logic [3:0] data_i = '0;
  logic cin0_i = 0, cin1_i = 0, cin_sel_i = 0, chain_i = 0;
  logic [15:0] cfg_lut_i = 16'hAAAA;
  logic cfg_arith_i = 0;
  logic [1:0] cfg_ff_i = 2'b00;
  logic cfg_clk_sel_i = 0, cfg_ena_sel_i = 0, cfg_clr_sel_i = 0, cfg_aload_i = 0;
  logic cfg_bypass_i = 0, cfg_pack_i = 0, cfg_chain_i = 0;
  logic comb_o, cell_o, chain_o, cout0_o, cout1_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk0_i = ~clk0_i;

  lec_cell u0 (.*);

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk0_i);
    @(negedge clk0_i);
  endtask

  function automatic logic maj(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic t_reset();
    #1;
    chk("R9 reset q", chain_o, 1'b0);
    chk("R11 reset cell", cell_o, 1'b0);
    tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic t_lut();
    logic [15:0] tabs [3] = '{16'h8000, 16'h6996, 16'hA5C3};
    cfg_bypass_i = 1;
    foreach (tabs[t]) begin
      cfg_lut_i = tabs[t];
      for (int i = 0; i < 16; i++) begin
        data_i = 4'(i);
        #1;
        chk("R1 lut", comb_o, tabs[t][i]);
        chk("R11 bypass", cell_o, tabs[t][i]);
      end
    end
    cfg_bypass_i = 0;
    cfg_lut_i = 16'hAAAA;
    data_i = '0;
  endtask

  task automatic t_arith();
    logic b, c;
    cfg_arith_i = 1;
    for (int add = 0; add < 2; add++)
      for (int v = 0; v < 32; v++) begin
        addnsub_i = add[0];
        data_i = {2'b00, v[1:0]};
        cin0_i = v[2]; cin1_i = v[3]; cin_sel_i = v[4];
        #1;
        b = v[1] ^ ~add[0];
        c = v[4] ? v[3] : v[2];
        chk("R2 sum", comb_o, v[0] ^ b ^ c);
        chk("R3 cout0", cout0_o, maj(v[0], b, v[2]));
        chk("R3 cout1", cout1_o, maj(v[0], b, v[3]));
      end
    cfg_arith_i = 0; addnsub_i = 1; cin0_i = 0; cin1_i = 0; cin_sel_i = 0;
    data_i = '0;
  endtask

  task automatic t_dreg();
    cfg_ff_i = 2'b00;
    data_i = 4'b0001; tick();
    chk("R4 d load 1", cell_o, 1'b1);
    chk("R11 chain_o", chain_o, 1'b1);
    data_i = 4'b0000; tick();
    chk("R4 d load 0", cell_o, 1'b0);
    cfg_pack_i = 1; data_i = 4'b1000; tick();
    chk("R4 packed d4", cell_o, 1'b1);
    cfg_chain_i = 1; chain_i = 0; tick();
    chk("R4 chain over packed", cell_o, 1'b0);
    chain_i = 1; tick();
    chk("R4 chain 1", chain_o, 1'b1);
    cfg_chain_i = 0; cfg_pack_i = 0; chain_i = 0; data_i = '0;
    sclr_i = 1; tick(); sclr_i = 0;
  endtask

  task automatic t_fftypes();
    cfg_ff_i = 2'b01;
    data_i = 4'b0001; tick(); chk("R5 T toggle up", chain_o, 1'b1);
    tick();                   chk("R5 T toggle down", chain_o, 1'b0);
    data_i = 4'b0000; tick(); chk("R5 T hold", chain_o, 1'b0);
    cfg_ff_i = 2'b10;
    data_i = 4'b0001; tick(); chk("R5 JK set", chain_o, 1'b1);
    data_i = 4'b0100; tick(); chk("R5 JK clear", chain_o, 1'b0);
    data_i = 4'b0101; tick(); chk("R5 JK toggle", chain_o, 1'b1);
    tick();                   chk("R5 JK toggle again", chain_o, 1'b0);
    data_i = 4'b0000; tick(); chk("R5 JK hold", chain_o, 1'b0);
    cfg_ff_i = 2'b11;
    data_i = 4'b0001; tick(); chk("R5 SR set", chain_o, 1'b1);
    data_i = 4'b0101; tick(); chk("R5 SR both hold 1", chain_o, 1'b1);
    data_i = 4'b0100; tick(); chk("R5 SR reset", chain_o, 1'b0);
    data_i = 4'b0101; tick(); chk("R5 SR both hold 0", chain_o, 1'b0);
    cfg_ff_i = 2'b00; data_i = '0;
  endtask

  task automatic t_enable();
    ena0_i = 0; data_i = 4'b0001; tick();
    chk("R6 ena0 low holds", chain_o, 1'b0);
    cfg_ena_sel_i = 1; ena1_i = 1; tick();
    chk("R6 ena1 selected", chain_o, 1'b1);
    ena1_i = 0; ena0_i = 1; data_i = 4'b0000; tick();
    chk("R6 ena0 ignored when ena1 selected", chain_o, 1'b1);
    cfg_ena_sel_i = 0;
  endtask

  task automatic t_clksel();
    data_i = 4'b0000; cfg_clk_sel_i = 1; tick();
    chk("R7 clk0 ignored", chain_o, 1'b1);
    #2 clk1_i = 1; #2 clk1_i = 0; #1;
    chk("R7 clk1 edge", chain_o, 1'b0);
    @(negedge clk0_i);
    cfg_clk_sel_i = 0;
  endtask

  task automatic t_sync();
    data_i = 4'b0001; tick(); chk("R8 preload", chain_o, 1'b1);
    sclr_i = 1; sload_i = 1; data_i = 4'b0101; tick();
    chk("R8 sclr over sload", chain_o, 1'b0);
    sclr_i = 0; data_i = 4'b0100; tick();
    chk("R8 sload d3 1", chain_o, 1'b1);
    data_i = 4'b0001; tick();
    chk("R8 sload d3 0", chain_o, 1'b0);
    sload_i = 0; tick();
    chk("R8 normal after load", chain_o, 1'b1);
    ena0_i = 0; sclr_i = 1; tick();
    chk("R8 sclr gated by enable", chain_o, 1'b1);
    sclr_i = 0; ena0_i = 1;
  endtask

  task automatic t_async();
    aclr0_i = 1; #1; chk("R9 aclr0 immediate", chain_o, 1'b0);
    tick(); aclr0_i = 0;
    data_i = 4'b0001; tick(); chk("R9 recover", chain_o, 1'b1);
    cfg_clr_sel_i = 1; aclr0_i = 1; #1;
    chk("R9 unselected clear ignored", chain_o, 1'b1);
    tick(); aclr0_i = 0;
    aclr1_i = 1; #1; chk("R9 aclr1 immediate", chain_o, 1'b0);
    tick(); aclr1_i = 0; cfg_clr_sel_i = 0;
    data_i = 4'b0000; tick();
    cfg_aload_i = 0; apre_i = 1; #1; chk("R10 preset", chain_o, 1'b1);
    tick(); chk("R10 held over clock", chain_o, 1'b1);
    apre_i = 0; data_i = 4'b0001; tick();
    cfg_aload_i = 1; adata_i = 0; apre_i = 1; #1;
    chk("R10 async load 0", chain_o, 1'b0);
    tick(); apre_i = 0; tick();
    chk("R10 release", chain_o, 1'b1);
    adata_i = 0; cfg_aload_i = 0;
    apre_i = 1; aclr0_i = 1; #1;
    chk("R9 clear beats preset", chain_o, 1'b0);
    tick(); apre_i = 0; aclr0_i = 0; tick();
    chk("R9 pre-reset value", chain_o, 1'b1);
    rst_ni = 0; #1; chk("R9 chip reset", chain_o, 1'b0);
    tick(); rst_ni = 1; tick();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk0_i);
    t_reset();
    t_lut();
    t_arith();
    t_dreg();
    t_fftypes();
    t_enable();
    t_clksel();
    t_sync();
    t_async();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule